// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI master from the bus clock. Each time the serial clock is due to change level, it raises a one-cycle toggle pulse, and it keeps a matching clock level. The shifter uses the pulse to time its sample and launch edges. The polarity stage applies its inversion to the level downstream. The level sits at 0 whenever the divider is idle.

Two division laws are selectable. The power-of-two law divides the bus clock by 2^(N+1). The linear law divides it by 2*(N+1). N is an 8-bit divider value. The law bit and N are captured into shadow state only while the controller enable is low. While the enable is high, the shadow state is frozen and the half-period counter runs. Each counting phase starts fresh when the enable rises.

Top module: `spiclk_divider`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sclk_toggle` is 0 and `sclk_level` is 0.
- R2: While `enable` is low, `sclk_toggle` stays 0 and `sclk_level` stays 0. Both outputs are registered, so they follow `enable` one cycle later.
- R3: With `law_sel` = 0 (power-of-two law) captured, the half period is 2^N bus cycles, so the output frequency is the bus clock divided by 2^(N+1).
- R4: Under the power-of-two law, N above 15 is treated as 15, which gives a half period of 32768 cycles.
- R5: With `law_sel` = 1 (linear law) captured, the half period is N+1 bus cycles for every N from 0 to 255.
- R6: `law_sel` and `div_val` are captured on each clock edge where `enable` is low. Changes made while `enable` is high have no effect until `enable` has been low for at least one edge.
- R7: The half period is counted from the first edge on which `enable` is sampled high. The first pulse appears a whole half period after that edge. A disable in mid-period discards the partial count.
- R8: `sclk_toggle` is high exactly in the cycles where `sclk_level` inverts. The only other way `sclk_level` can change is a fall to the idle level 0. Since both halves are equal, the duty cycle is 50%.
- R9: At the fastest setting (either law with N = 0), the pulse is high on every enabled cycle, so the level toggles at the bus clock rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; runs the divider when high, opens configuration capture when low |
| law_sel | input | 1 | Division law: 0 = power-of-two, 1 = linear |
| div_val | input | 8 | Divider value N |
| sclk_toggle | output | 1 | One-cycle pulse on each serial clock level change |
| sclk_level | output | 1 | Serial clock level before polarity inversion; 0 when idle |

## Verification
Two events can land in the same cycle.

The first is a change of configuration arriving on the same edge as the enable rise. The bench writes a new divider value and law together with the rising enable. The reference model treats the old, captured setting as governing the whole enabled phase.

The second is a disable landing on a cycle where a toggle was due. The bench drops the enable exactly on a pulse cycle and checks that the level falls straight to idle. It then checks that no pulse survives, and that the next enable restarts a full half period.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

    typedef enum logic {
        LAW_POW2   = 1'b0,
        LAW_LINEAR = 1'b1
    } div_law_e;

    // Limits the power-of-two exponent to its legal range.
    function automatic int clamp_exp(input int n, input int lim);
        return (n > lim) ? lim : n;
    endfunction

endpackage

// File: rtl/spiclk_cfg_hold.sv
module spiclk_cfg_hold
    import spiclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             law_i,
    input  logic [DIV_W-1:0] div_i,
    output div_law_e         law_o,
    output logic [DIV_W-1:0] div_o
);

    typedef struct packed {
        div_law_e         law;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{law: LAW_POW2, div: '0};
        end else if (!enable) begin
            cfg_q <= '{law: div_law_e'(law_i), div: div_i};
        end
    end

    assign law_o = cfg_q.law;
    assign div_o = cfg_q.div;

    // R6
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(enable) && !$past(rst) |-> $stable(cfg_q));

endmodule

// File: rtl/spiclk_period_sel.sv
module spiclk_period_sel
    import spiclk_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int POW2_MAX = 15,
    parameter int CNT_W    = 15
) (
    input  div_law_e         law,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] half_last
);

    logic [CNT_W-1:0] pow2_last;
    logic [CNT_W-1:0] lin_last;

    always_comb begin
        pow2_last = (CNT_W'(1) << clamp_exp(int'(div), POW2_MAX)) - CNT_W'(1);
        lin_last  = CNT_W'(div);
        half_last = (law == LAW_LINEAR) ? lin_last : pow2_last;
    end

endmodule

// File: rtl/spiclk_phase_ctr.sv
module spiclk_phase_ctr #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] half_last,
    output logic             toggle_o,
    output logic             level_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             tog_q;
    logic             lvl_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
            lvl_q <= 1'b0;
        end else if (cnt_q == half_last) begin
            cnt_q <= '0;
            tog_q <= 1'b1;
            lvl_q <= ~lvl_q;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            tog_q <= 1'b0;
        end
    end

    assign toggle_o = tog_q;
    assign level_o  = lvl_q;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !tog_q && !lvl_q);

    // R2
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> !tog_q && !lvl_q);

    // R8
    pulse_flip_chk: assert property (@(posedge clk) disable iff (rst)
        tog_q |-> lvl_q != $past(lvl_q));

    // R8
    level_move_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_q != $past(lvl_q) |-> tog_q || !lvl_q);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= half_last);

endmodule

// File: rtl/spiclk_divider.sv
module spiclk_divider
    import spiclk_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int POW2_MAX = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             law_sel,
    input  logic [DIV_W-1:0] div_val,
    output logic             sclk_toggle,
    output logic             sclk_level
);

    localparam int CNT_W = (POW2_MAX > DIV_W) ? POW2_MAX : DIV_W;

    div_law_e         law_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] half_last;

    spiclk_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .law_i  (law_sel),
        .div_i  (div_val),
        .law_o  (law_q),
        .div_o  (div_q)
    );

    spiclk_period_sel #(.DIV_W(DIV_W), .POW2_MAX(POW2_MAX), .CNT_W(CNT_W)) u_sel (
        .law       (law_q),
        .div       (div_q),
        .half_last (half_last)
    );

    spiclk_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .half_last (half_last),
        .toggle_o  (sclk_toggle),
        .level_o   (sclk_level)
    );

endmodule

// File: tb/tb_spiclk_divider.sv
module tb_spiclk_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       law_sel = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic       sclk_toggle;
    logic       sclk_level;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model state
    int m_law = 0;
    int m_div = 0;
    int m_elapsed = 0;
    bit m_tog = 0;
    bit m_lvl = 0;

    always #4 clk = ~clk;

    spiclk_divider dut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .law_sel     (law_sel),
        .div_val     (div_val),
        .sclk_toggle (sclk_toggle),
        .sclk_level  (sclk_level)
    );

    function automatic int half_len(input int law, input int n);
        if (law == 1) return n + 1;
        return 1 << ((n > 15) ? 15 : n);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_law = 0; m_div = 0; m_elapsed = 0; m_tog = 0; m_lvl = 0;
        end else if (!enable) begin
            m_law = int'(law_sel); m_div = int'(div_val);
            m_elapsed = 0; m_tog = 0; m_lvl = 0;
        end else begin
            m_elapsed++;
            m_tog = (m_elapsed % half_len(m_law, m_div)) == 0;
            m_lvl = ((m_elapsed / half_len(m_law, m_div)) % 2) == 1;
        end
        if (cyc > 190000 && !done) begin
            failures++;
            $display("FAIL watchdog: cycle=%0d expected finish before 190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (sclk_toggle !== m_tog || sclk_level !== m_lvl) begin
                failures++;
                $display("FAIL %s: toggle=%0b level=%0b expected toggle=%0b level=%0b at cycle %0d",
                         tag, sclk_toggle, sclk_level, m_tog, m_lvl, cyc);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_cfg(input string req, input bit law, input int n, input int cycles);
        tag = req;
        enable = 1'b0; law_sel = law; div_val = 8'(n);
        wait_cyc(2);
        enable = 1'b1;
        wait_cyc(cycles);
        enable = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        // R1: reset state
        wait_cyc(3);
        chk("R1", sclk_toggle, 1'b0);
        chk("R1", sclk_level, 1'b0);
        rst = 1'b0;
        wait_cyc(1);
        chk("R1", sclk_level, 1'b0);

        // R2: disabled, inputs wiggling, no activity
        tag = "R2";
        for (int i = 0; i < 10; i++) begin
            law_sel = i[0]; div_val = 8'(i * 7);
            wait_cyc(1);
            chk("R2", sclk_toggle, 1'b0);
        end

        // R5: linear law
        run_cfg("R5", 1'b1, 3, 30);
        run_cfg("R5", 1'b1, 7, 50);
        run_cfg("R5", 1'b1, 255, 1030);

        // R3: power-of-two law
        run_cfg("R3", 1'b0, 2, 30);
        run_cfg("R3", 1'b0, 5, 200);

        // R9: fastest setting under both laws
        run_cfg("R9", 1'b0, 0, 12);
        run_cfg("R9", 1'b1, 0, 1);
        tag = "R9";
        enable = 1'b1;
        wait_cyc(1);
        chk("R9", sclk_toggle, 1'b1);
        wait_cyc(1);
        chk("R9", sclk_toggle, 1'b1);
        enable = 1'b0;
        wait_cyc(2);

        // R4: exponent above 15 clamps to a 32768-cycle half period
        run_cfg("R4", 1'b0, 20, 32800);

        // R6: changes while enabled, including on the enabling edge, are ignored
        tag = "R6";
        law_sel = 1'b1; div_val = 8'd3;
        wait_cyc(2);
        enable = 1'b1; div_val = 8'd9; law_sel = 1'b0;
        wait_cyc(4);
        chk("R6", sclk_toggle, 1'b1);
        wait_cyc(20);
        enable = 1'b0;
        wait_cyc(1);
        enable = 1'b1;
        wait_cyc(4);
        chk("R6", sclk_toggle, 1'b0);
        wait_cyc(60);

        // R7: disable exactly on a pulse cycle, then restart from fresh
        tag = "R7";
        enable = 1'b0; law_sel = 1'b1; div_val = 8'd4;
        wait_cyc(2);
        enable = 1'b1;
        wait_cyc(5);
        chk("R7", sclk_toggle, 1'b1);
        enable = 1'b0;
        wait_cyc(1);
        chk("R7", sclk_level, 1'b0);
        chk("R7", sclk_toggle, 1'b0);
        enable = 1'b1;
        wait_cyc(3);
        enable = 1'b0;
        wait_cyc(1);
        enable = 1'b1;
        wait_cyc(4);
        chk("R7", sclk_toggle, 1'b0);
        wait_cyc(1);
        chk("R7", sclk_toggle, 1'b1);

        // R8: equal halves, pulse aligned with every level change
        tag = "R8";
        wait_cyc(40);
        enable = 1'b0;
        wait_cyc(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule